// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the register front end of an eight-input programmable interrupt controller. A CPU writes bytes to it through a bus that has one address bit, which selects an even or an odd port, and a write strobe. After reset or after a restart word, the block steps through a short initialization sequence. That sequence always takes a restart word and a vector word. A cascade word and a mode word are optional, and the restart word decides whether each one is expected. Once the sequence is complete, the block sorts each write by port and by data bits 4 and 3. A write can load the interrupt mask, issue an end-of-interrupt or priority command, or change the read select and the special mask mode.

The block presents its outputs to the priority resolver and the acknowledge logic beside it. These outputs are the stored configuration (vector base, cascade map, trigger mode, single/cascade flag, automatic end-of-interrupt, buffered mode, special nesting), the mask, and single-cycle command pulses. Cascading is kept only as stored configuration. The block also drives a combinational read port. That port returns the request or in-service vector, which it takes from outside the block, or the mask.

Top module: `pic_cmd_front`

## Requirements
- R1: After synchronous reset, `ready` is 0, `irq_mask` is 8'hFF, `read_irr` is 1, `special_mask` is 0, every configuration output is 0 and every command pulse is 0.
- R2: A write to the even port (addr0=0) with data bit 4 set is a restart word at any time. One cycle later `ready` is 0, `level_trig` equals bit 3, `single_mode` equals bit 1, `irq_mask` is 8'h00, `read_irr` is 1, and `special_mask`, `casc_map`, `auto_eoi`, `buf_mode` and `nested_special` are 0.
- R3: The first odd-port write after a restart word loads `vec_base` from data bits 7:3.
- R4: When the restart word had bit 1 = 0, the next odd-port write after the vector word loads `casc_map` with all eight data bits.
- R5: When the restart word had bit 0 = 1, the next odd-port write loads the mode word: `auto_eoi` from bit 1, `buf_mode` from bits 3:2 and `nested_special` from bit 4. `ready` rises one cycle after the last expected word.
- R6: When the restart word had bit 1 = 1 and bit 0 = 0, `ready` rises one cycle after the vector word, and the next odd-port write loads the mask.
- R7: Before `ready`, an even-port write with data bit 4 = 0 has no effect: it produces no pulse and changes neither `read_irr` nor `special_mask`.
- R8: Once `ready` is set, an odd-port write loads `irq_mask` with the data byte one cycle later.
- R9: Once `ready` is set, an even-port write with D4=0 and D3=0 is a command word. Its code is bits 7:5. One cycle later the block raises these pulses for exactly one cycle, with `cmd_level` = bits 2:0:
  - 001 gives `eoi_pulse`.
  - 011 gives `eoi_pulse` and `eoi_specific`.
  - 100 gives `auto_rot_pulse`.
  - 101 gives `eoi_pulse` and `rotate_pulse`.
  - 110 gives `set_prio_pulse`.
  - 111 gives `eoi_pulse`, `eoi_specific` and `rotate_pulse`.
- R10: Command codes 000 and 010 raise no pulse.
- R11: Once `ready` is set, an even-port write with D4=0 and D3=1 is a control word. When its bit 1 is 1, `read_irr` takes bit 0. When its bit 1 is 0, `read_irr` is unchanged.
- R12: A control word with bit 2 set raises `poll_pulse` for exactly one cycle, one cycle after the write.
- R13: A control word with bit 6 set loads `special_mask` from bit 5. When bit 6 is 0, `special_mask` is unchanged.
- R14: `rd_data` is `irq_mask` when addr0=1. When addr0=0 it is `irr_in` if `read_irr` is 1 and `isr_in` if `read_irr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr0 | input | 1 | Port select: 0 even, 1 odd |
| wr_data | input | 8 | Write data byte |
| irr_in | input | 8 | Pending-request vector from the request logic |
| isr_in | input | 8 | In-service vector from the service logic |
| rd_data | output | 8 | Read data for the port on addr0 |
| ready | output | 1 | Initialization complete |
| vec_base | output | 5 | Upper five bits of the vector number |
| casc_map | output | 8 | Stored cascade word |
| level_trig | output | 1 | 1 = level triggered, 0 = edge |
| single_mode | output | 1 | 1 = single controller, no cascade word |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| buf_mode | output | 2 | Buffered master/slave selection |
| nested_special | output | 1 | Special fully nested mode |
| irq_mask | output | 8 | Interrupt mask, 1 blocks a line |
| read_irr | output | 1 | Even-port read select: 1 request, 0 in-service |
| special_mask | output | 1 | Special mask mode |
| eoi_pulse | output | 1 | End-of-interrupt command pulse |
| eoi_specific | output | 1 | Qualifies eoi_pulse as level-specific |
| rotate_pulse | output | 1 | Rotate priority with the EOI |
| auto_rot_pulse | output | 1 | Rotate-in-automatic-EOI command pulse |
| set_prio_pulse | output | 1 | Set lowest-priority level pulse |
| poll_pulse | output | 1 | Poll command pulse |
| cmd_level | output | 3 | Level carried by the last command word |

## Verification
The bench walks the two optional-word branches of the initialization sequence. If a branch skips the wrong word, the vector or mask data lands in the cascade map or the mode fields, and `ready` rises at the wrong step. It restarts the sequence in the middle. A design that does not reset its step counter would take the new vector byte as a cascade word. It sends command and control words before `ready`, which a careless decoder would turn into pulses or select changes. It sweeps all eight command codes, including the two silent ones, and clears the control-word gating bits, which catches designs that act on bit 0 or bit 5 while their enable bit is clear.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int NUM_IRQ = 8;
    localparam int DATA_W  = 8;
    localparam int LVL_W   = $clog2(NUM_IRQ);
    localparam int VEC_W   = DATA_W - LVL_W;

    // Steps of the initialization sequence
    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_VEC,
        ST_CASC,
        ST_MODE,
        ST_READY
    } init_state_e;

    // Classification of one bus write
    typedef enum logic [2:0] {
        W_NONE,
        W_INIT1,
        W_ODD,
        W_CMD2,
        W_CMD3
    } wr_kind_e;

    typedef struct packed {
        logic [VEC_W-1:0]   vec_base;
        logic [NUM_IRQ-1:0] casc_map;
        logic               level_trig;
        logic               single;
        logic               auto_eoi;
        logic [1:0]         buf_mode;
        logic               sfnm;
    } init_cfg_t;

    typedef struct packed {
        logic eoi;
        logic eoi_specific;
        logic rotate;
        logic auto_rot;
        logic set_prio;
    } cmd_pulse_t;

    function automatic wr_kind_e classify(input logic we, input logic a0,
                                          input logic [DATA_W-1:0] d);
        wr_kind_e k;
        if (!we)        k = W_NONE;
        else if (a0)    k = W_ODD;
        else if (d[4])  k = W_INIT1;
        else if (d[3])  k = W_CMD3;
        else            k = W_CMD2;
        return k;
    endfunction

    function automatic cmd_pulse_t decode_cmd(input logic [2:0] code);
        cmd_pulse_t p;
        p = '0;
        case (code)
            3'b001: p.eoi = 1'b1;
            3'b011: begin p.eoi = 1'b1; p.eoi_specific = 1'b1; end
            3'b100: p.auto_rot = 1'b1;
            3'b101: begin p.eoi = 1'b1; p.rotate = 1'b1; end
            3'b110: p.set_prio = 1'b1;
            3'b111: begin p.eoi = 1'b1; p.eoi_specific = 1'b1; p.rotate = 1'b1; end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] data,
    output logic              ready,
    output init_cfg_t         cfg
);

    init_state_e state;
    logic        want_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_UNINIT;
            cfg       <= '0;
            want_mode <= 1'b0;
        end else if (kind == W_INIT1) begin
            state          <= ST_VEC;
            cfg            <= '0;
            cfg.level_trig <= data[3];
            cfg.single     <= data[1];
            want_mode      <= data[0];
        end else if (kind == W_ODD) begin
            case (state)
                ST_VEC: begin
                    cfg.vec_base <= data[DATA_W-1:LVL_W];
                    if (!cfg.single)   state <= ST_CASC;
                    else if (want_mode) state <= ST_MODE;
                    else                state <= ST_READY;
                end
                ST_CASC: begin
                    cfg.casc_map <= data;
                    state        <= want_mode ? ST_MODE : ST_READY;
                end
                ST_MODE: begin
                    cfg.auto_eoi <= data[1];
                    cfg.buf_mode <= data[3:2];
                    cfg.sfnm     <= data[4];
                    state        <= ST_READY;
                end
                default: ;
            endcase
        end
    end

    assign ready = (state == ST_READY);

    // R2
    icw1_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == W_INIT1) |=> (!ready && state == ST_VEC));

    // R6
    short_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VEC && kind == W_ODD && cfg.single && !want_mode) |=> ready);

    // R4
    casc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == W_NONE) |=> $stable(cfg.casc_map));

endmodule

// File: rtl/pic_op_decode.sv
module pic_op_decode
    import pic_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ready,
    input  wr_kind_e           kind,
    input  logic [DATA_W-1:0]  data,
    output logic [NUM_IRQ-1:0] mask,
    output logic               read_irr,
    output logic               special_mask,
    output cmd_pulse_t         pulses,
    output logic               poll,
    output logic [LVL_W-1:0]   level
);

    logic init_hit;
    logic op_ok;

    assign init_hit = (kind == W_INIT1);
    assign op_ok    = ready && !init_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask         <= '1;
            read_irr     <= 1'b1;
            special_mask <= 1'b0;
            pulses       <= '0;
            poll         <= 1'b0;
            level        <= '0;
        end else begin
            pulses <= '0;
            poll   <= 1'b0;
            if (init_hit) begin
                mask         <= '0;
                read_irr     <= 1'b1;
                special_mask <= 1'b0;
            end else if (op_ok) begin
                case (kind)
                    W_ODD:  mask <= data;
                    W_CMD2: begin
                        level  <= data[LVL_W-1:0];
                        pulses <= decode_cmd(data[7:5]);
                    end
                    W_CMD3: begin
                        if (data[1]) read_irr     <= data[0];
                        if (data[6]) special_mask <= data[5];
                        poll <= data[2];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9
    eoi_src_chk: assert property (@(posedge clk) disable iff (rst)
        pulses.eoi |-> $past(ready && kind == W_CMD2));

    // R12
    poll_src_chk: assert property (@(posedge clk) disable iff (rst)
        poll |-> $past(ready && kind == W_CMD3 && data[2]));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (kind != W_ODD && kind != W_INIT1) |=> $stable(mask));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pulses.eoi, pulses.auto_rot, pulses.set_prio}));

    // R7
    no_early_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && kind != W_INIT1) |=> ($stable(read_irr) && $stable(special_mask) && !poll));

endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
    import pic_cmd_pkg::*;
(
    input  logic               addr0,
    input  logic               read_irr,
    input  logic [NUM_IRQ-1:0] irr_in,
    input  logic [NUM_IRQ-1:0] isr_in,
    input  logic [NUM_IRQ-1:0] mask,
    output logic [DATA_W-1:0]  rd_data
);

    always_comb begin
        if (addr0)         rd_data = mask;
        else if (read_irr) rd_data = irr_in;
        else               rd_data = isr_in;
    end

endmodule

// File: rtl/pic_cmd_front.sv
module pic_cmd_front
    import pic_cmd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         addr0,
    input  logic [7:0]   wr_data,
    input  logic [7:0]   irr_in,
    input  logic [7:0]   isr_in,
    output logic [7:0]   rd_data,
    output logic         ready,
    output logic [4:0]   vec_base,
    output logic [7:0]   casc_map,
    output logic         level_trig,
    output logic         single_mode,
    output logic         auto_eoi,
    output logic [1:0]   buf_mode,
    output logic         nested_special,
    output logic [7:0]   irq_mask,
    output logic         read_irr,
    output logic         special_mask,
    output logic         eoi_pulse,
    output logic         eoi_specific,
    output logic         rotate_pulse,
    output logic         auto_rot_pulse,
    output logic         set_prio_pulse,
    output logic         poll_pulse,
    output logic [2:0]   cmd_level
);

    wr_kind_e   kind;
    init_cfg_t  cfg;
    cmd_pulse_t pulses;

    assign kind = classify(wr_en, addr0, wr_data);

    pic_init_fsm u_init (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .data  (wr_data),
        .ready (ready),
        .cfg   (cfg)
    );

    pic_op_decode u_op (
        .clk          (clk),
        .rst          (rst),
        .ready        (ready),
        .kind         (kind),
        .data         (wr_data),
        .mask         (irq_mask),
        .read_irr     (read_irr),
        .special_mask (special_mask),
        .pulses       (pulses),
        .poll         (poll_pulse),
        .level        (cmd_level)
    );

    pic_read_mux u_rd (
        .addr0    (addr0),
        .read_irr (read_irr),
        .irr_in   (irr_in),
        .isr_in   (isr_in),
        .mask     (irq_mask),
        .rd_data  (rd_data)
    );

    assign vec_base       = cfg.vec_base;
    assign casc_map       = cfg.casc_map;
    assign level_trig     = cfg.level_trig;
    assign single_mode    = cfg.single;
    assign auto_eoi       = cfg.auto_eoi;
    assign buf_mode       = cfg.buf_mode;
    assign nested_special = cfg.sfnm;
    assign eoi_pulse      = pulses.eoi;
    assign eoi_specific   = pulses.eoi_specific;
    assign rotate_pulse   = pulses.rotate;
    assign auto_rot_pulse = pulses.auto_rot;
    assign set_prio_pulse = pulses.set_prio;

    // R14
    rd_odd_chk: assert property (@(posedge clk) disable iff (rst)
        addr0 |-> (rd_data == irq_mask));

endmodule

// File: tb/tb_pic_cmd_front.sv
`timescale 1ns/1ps
module tb_pic_cmd_front;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic addr0 = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] irr_in = 8'hC3;
    logic [7:0] isr_in = 8'h24;
    logic [7:0] rd_data, casc_map, irq_mask;
    logic [4:0] vec_base;
    logic [1:0] buf_mode;
    logic [2:0] cmd_level;
    logic ready, level_trig, single_mode, auto_eoi, nested_special, read_irr, special_mask;
    logic eoi_pulse, eoi_specific, rotate_pulse, auto_rot_pulse, set_prio_pulse, poll_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pic_cmd_front dut (.*);

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] pulse_vec();
        return {2'b00, poll_pulse, eoi_pulse, eoi_specific, rotate_pulse, auto_rot_pulse, set_prio_pulse};
    endfunction

    // Drive one write; returns at the next falling edge, after the capturing edge
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr0 = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready", ready, 0);
        chk("R1 mask", irq_mask, 8'hFF);
        chk("R1 read_irr", read_irr, 1);
        chk("R1 special_mask", special_mask, 0);
        chk("R1 pulses", pulse_vec(), 0);
        chk("R1 cfg", {vec_base, level_trig, single_mode, auto_eoi}, 0);
        chk("R1 casc", casc_map, 0);
    endtask

    task automatic t_full_init();
        wr(0, 8'h11);
        chk("R2 ready low", ready, 0);
        chk("R2 mask cleared", irq_mask, 8'h00);
        chk("R2 single", single_mode, 0);
        chk("R2 level", level_trig, 0);
        wr(0, 8'h20);
        chk("R7 no pulse before ready", pulse_vec(), 0);
        wr(0, 8'h0A);
        chk("R7 read_irr kept", read_irr, 1);
        wr(1, 8'h48);
        chk("R3 vec_base", vec_base, 5'h09);
        chk("R3 not ready", ready, 0);
        wr(1, 8'h04);
        chk("R4 casc_map", casc_map, 8'h04);
        chk("R4 not ready", ready, 0);
        wr(1, 8'h1E);
        chk("R5 auto_eoi", auto_eoi, 1);
        chk("R5 buf_mode", buf_mode, 2'b11);
        chk("R5 nested", nested_special, 1);
        chk("R5 ready", ready, 1);
        chk("R5 vec kept", vec_base, 5'h09);
    endtask

    task automatic t_mask();
        wr(1, 8'h5A);
        chk("R8 mask", irq_mask, 8'h5A);
        chk("R8 casc kept", casc_map, 8'h04);
        @(negedge clk); addr0 = 1'b1; #1;
        chk("R14 odd read", rd_data, 8'h5A);
    endtask

    task automatic t_cmd2();
        logic [7:0] exp;
        for (int c = 0; c < 8; c++) begin
            case (c)
                1: exp = 8'b0001_0000;
                3: exp = 8'b0001_1000;
                4: exp = 8'b0000_0010;
                5: exp = 8'b0001_0100;
                6: exp = 8'b0000_0001;
                7: exp = 8'b0001_1100;
                default: exp = 8'h00;
            endcase
            wr(0, {c[2:0], 2'b00, 3'(7 - c)});
            if (c == 0 || c == 2) chk("R10 silent code", pulse_vec(), exp);
            else                  chk("R9 pulses", pulse_vec(), exp);
            if (exp != 0) chk("R9 level", cmd_level, 8'(7 - c));
            @(negedge clk);
            chk("R9 one cycle", pulse_vec(), 0);
        end
    endtask

    task automatic t_cmd3();
        wr(0, 8'h0A);
        chk("R11 select ISR", read_irr, 0);
        @(negedge clk); addr0 = 1'b0; #1;
        chk("R14 even ISR", rd_data, 8'h24);
        wr(0, 8'h09);
        chk("R11 gated", read_irr, 0);
        wr(0, 8'h0B);
        chk("R11 select IRR", read_irr, 1);
        @(negedge clk); addr0 = 1'b0; #1;
        chk("R14 even IRR", rd_data, 8'hC3);
        wr(0, 8'h0C);
        chk("R12 poll", poll_pulse, 1);
        chk("R12 select kept", read_irr, 1);
        @(negedge clk);
        chk("R12 poll one cycle", poll_pulse, 0);
        wr(0, 8'h68);
        chk("R13 set", special_mask, 1);
        wr(0, 8'h08);
        chk("R13 gated", special_mask, 1);
        wr(0, 8'h48);
        chk("R13 clear", special_mask, 0);
    endtask

    task automatic t_short_init();
        wr(0, 8'h68);
        wr(0, 8'h1A);
        chk("R2 level", level_trig, 1);
        chk("R2 single", single_mode, 1);
        chk("R2 smm cleared", special_mask, 0);
        chk("R2 cfg cleared", {casc_map}, 0);
        chk("R2 mode cleared", {5'b0, auto_eoi, buf_mode}, 0);
        chk("R2 ready low", ready, 0);
        wr(1, 8'hF8);
        chk("R6 vec", vec_base, 5'h1F);
        chk("R6 ready", ready, 1);
        wr(1, 8'h33);
        chk("R6 mask", irq_mask, 8'h33);
        chk("R6 casc untouched", casc_map, 0);
    endtask

    task automatic t_restart();
        wr(0, 8'h11);
        wr(1, 8'h30);
        wr(0, 8'h1B);
        wr(1, 8'h80);
        chk("R2 restart vec", vec_base, 5'h10);
        chk("R2 restart casc", casc_map, 0);
        chk("R2 restart ready", ready, 0);
        wr(1, 8'h02);
        chk("R5 auto", auto_eoi, 1);
        chk("R5 ready", ready, 1);
        chk("R5 casc", casc_map, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_init();
        t_mask();
        t_cmd2();
        t_cmd3();
        t_short_init();
        t_restart();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule